// File: doc/BRIEF.md
# Bus Idle and Service-Request Indicator

This block drives one active-low flag toward a host controller. In its normal role the flag goes low once the serial vehicle network has stayed passive for 275 µs. It also gives a 1 µs low pulse when a new frame starts after a quiet gap of at least 239 µs that had not yet reached the idle threshold, so the host can tell that a message began after a near-idle bus.

After any reset the same flag serves a second purpose: it is a service request. It stays high for a short fixed interval, then goes low and stays low until the host completes a status/control exchange. After a further fixed tail it returns to its normal role. Power-on reset, the external reset pin and slow-clock detection all arrive here on the single reset input, so they all lead to the same handshake.

While the flag is low, an echo error or a host "next" request makes it blink high for 2 µs. All microsecond intervals come from the `CYC_PER_US` parameter and are rounded up to whole clock cycles.

Top module: `bus_idle_sreq`

## Requirements
- R1: In normal mode, `idle_n` goes low on the clock edge that completes 275 µs (ceil(275·CYC_PER_US) cycles) of continuous bus passivity. It does not go low one cycle earlier.
- R2: In normal mode, a clock edge that samples `bus_active` high clears the passive count and leaves `idle_n` high, unless a pulse from R6 or R8 applies.
- R3: While `rst_n` is low, `idle_n` is high. After release it stays high for 17 clock edges and goes low on the 17th. A reset in the middle of operation starts this sequence again.
- R4: After the boot interval, `idle_n` stays low until an edge samples `xfer_done` high. It then stays low for 40 + ceil(1.5·CYC_PER_US) more edges counting that edge, and goes high on the next edge.
- R5: On entry to normal mode the passive count starts from zero, so `idle_n` stays high until a full R1 lull has elapsed.
- R6: A passive-to-active edge of `bus_active` that follows a passive run of at least ceil(239·CYC_PER_US) cycles, but less than the R1 count, drives `idle_n` low for ceil(1·CYC_PER_US) cycles.
- R7: A passive-to-active edge that follows a shorter passive run produces no low pulse.
- R8: An edge that samples `echo_err` high while `idle_n` is low (not during boot) forces `idle_n` high for ceil(2·CYC_PER_US) cycles. After that the flag returns to the level its role gives it.
- R9: `next_req` behaves exactly like `echo_err` in R8.
- R10: `echo_err` and `next_req` have no effect when `idle_n` is high at the sampling edge.
- R11: In normal mode `xfer_done` has no effect on `idle_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on, pin or slow-clock) |
| bus_active | input | 1 | Network level, 1 = active, 0 = passive |
| xfer_done | input | 1 | One-cycle strobe: a status/control exchange finished |
| echo_err | input | 1 | One-cycle strobe: echo failure set the error flag |
| next_req | input | 1 | One-cycle strobe: host set the next bit |
| idle_n | output | 1 | Active-low idle / service-request flag |

## Verification
The output is decoded from registers without further delay. Every result therefore appears right after the clock edge that samples its cause: the 17th edge after reset release, the edge that samples the strobe or the rising bus level, and the edge that completes the lull. Inputs change on falling edges and the flag is read on falling edges. Each check waits an exact number of falling edges from its stimulus, taken from the formulas in the requirements. Each pulse width is checked on its last low or high cycle and again on the first cycle after it, so an error of one cycle in either direction is caught.

// File: rtl/idlr_pkg.sv
package idlr_pkg;

   typedef enum logic [1:0] {
      M_BOOT = 2'd0,
      M_SREQ = 2'd1,
      M_HOLD = 2'd2,
      M_NORM = 2'd3
   } idlr_mode_e;

   // tenths of a microsecond to clock cycles, rounded up
   function automatic int unsigned tenths_to_cyc(input int unsigned cyc_per_us,
                                                 input int unsigned tenths);
      return (cyc_per_us * tenths + 9) / 10;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/idlr_seq.sv
module idlr_seq
   import idlr_pkg::*;
#(
   parameter int unsigned BOOT_CYC = 17,
   parameter int unsigned TAIL_CYC = 52
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xfer_done,
   output idlr_mode_e mode_o
);
   localparam int unsigned CW = $clog2(max2(BOOT_CYC, TAIL_CYC) + 1);

   idlr_mode_e   mode_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_BOOT;
         cnt_q  <= '0;
      end else begin
         unique case (mode_q)
            M_BOOT: begin
               if (cnt_q == CW'(BOOT_CYC - 1)) begin
                  mode_q <= M_SREQ;
                  cnt_q  <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            M_SREQ: begin
               if (xfer_done) begin
                  mode_q <= M_HOLD;
                  cnt_q  <= '0;
               end
            end
            M_HOLD: begin
               if (cnt_q == CW'(TAIL_CYC - 1)) begin
                  mode_q <= M_NORM;
                  cnt_q  <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               mode_q <= M_NORM;
               cnt_q  <= '0;
            end
         endcase
      end
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/idlr_lull.sv
module idlr_lull #(
   parameter int unsigned IDLE_CYC  = 2200,
   parameter int unsigned EARLY_CYC = 1912
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         enable,
   input  logic                         bus_active,
   output logic                         idle_o,
   output logic                         early_o,
   output logic [$clog2(IDLE_CYC+1)-1:0] pcnt_o
);
   localparam int unsigned PW = $clog2(IDLE_CYC + 1);

   logic [PW-1:0] pcnt_q;
   logic          prev_q;
   logic          rise;

   assign rise = bus_active & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= bus_active;
         if (!enable || bus_active) begin
            pcnt_q <= '0;
         end else if (pcnt_q != PW'(IDLE_CYC)) begin
            pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end

   assign idle_o  = enable && (pcnt_q == PW'(IDLE_CYC));
   assign early_o = enable && rise &&
                    (pcnt_q >= PW'(EARLY_CYC)) && (pcnt_q < PW'(IDLE_CYC));
   assign pcnt_o  = pcnt_q;
endmodule

// File: rtl/idlr_oneshot.sv
module idlr_oneshot #(
   parameter int unsigned LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic busy_o
);
   localparam int unsigned LW = $clog2(LEN + 1);

   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (trig) begin
         cnt_q <= LW'(LEN);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/bus_idle_sreq.sv
module bus_idle_sreq
   import idlr_pkg::*;
#(
   parameter int unsigned CYC_PER_US  = 50,
   parameter int unsigned BOOT_CYC    = 17,
   parameter int unsigned TAIL_FIXED  = 40,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_active,
   input  logic xfer_done,
   input  logic echo_err,
   input  logic next_req,
   output logic idle_n
);
   localparam int unsigned IDLE_CYC  = tenths_to_cyc(CYC_PER_US, 2750);
   localparam int unsigned EARLY_CYC = tenths_to_cyc(CYC_PER_US, 2390);
   localparam int unsigned LO_CYC    = tenths_to_cyc(CYC_PER_US, 10);
   localparam int unsigned HI_CYC    = tenths_to_cyc(CYC_PER_US, 20);
   localparam int unsigned TAIL_CYC  = TAIL_FIXED + tenths_to_cyc(CYC_PER_US, 15);
   localparam int unsigned PW        = $clog2(IDLE_CYC + 1);

   if (CYC_PER_US < 1) begin : g_bad_rate
      $error("CYC_PER_US must be at least 1");
   end
   if (BOOT_CYC < 1) begin : g_bad_boot
      $error("BOOT_CYC must be at least 1");
   end
   if (EARLY_CYC >= IDLE_CYC) begin : g_bad_window
      $error("early window must open before the idle threshold");
   end

   logic bus_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign bus_s = bus_active;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], bus_active};
      end
      assign bus_s = sync_q[SYNC_STAGES-1];
   end

   idlr_mode_e    mode;
   logic          norm;
   logic          lull_idle;
   logic          early;
   logic [PW-1:0] pcnt;
   logic          lo_busy;
   logic          hi_busy;
   logic          hi_trig;
   logic          flag_low;

   idlr_seq #(
      .BOOT_CYC (BOOT_CYC),
      .TAIL_CYC (TAIL_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer_done (xfer_done),
      .mode_o    (mode)
   );

   assign norm = (mode == M_NORM);

   idlr_lull #(
      .IDLE_CYC  (IDLE_CYC),
      .EARLY_CYC (EARLY_CYC)
   ) u_lull (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (norm),
      .bus_active (bus_s),
      .idle_o     (lull_idle),
      .early_o    (early),
      .pcnt_o     (pcnt)
   );

   idlr_oneshot #(.LEN(LO_CYC)) u_lo (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (early),
      .busy_o (lo_busy)
   );

   assign hi_trig = (echo_err | next_req) & ~idle_n & (mode != M_BOOT);

   idlr_oneshot #(.LEN(HI_CYC)) u_hi (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (hi_trig),
      .busy_o (hi_busy)
   );

   always_comb begin
      unique case (mode)
         M_BOOT:  flag_low = 1'b0;
         M_SREQ,
         M_HOLD:  flag_low = 1'b1;
         default: flag_low = lull_idle | lo_busy;
      endcase
   end

   assign idle_n = ~flag_low | hi_busy;
endmodule

// File: rtl/bus_idle_sreq_chk.sv
module bus_idle_sreq_chk
   import idlr_pkg::*;
#(
   parameter int unsigned BOOT_CYC = 17,
   parameter int unsigned IDLE_CYC = 2200,
   parameter int unsigned PW       = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_active,
   input logic          echo_err,
   input logic          next_req,
   input logic          idle_n,
   input idlr_mode_e    mode,
   input logic          lo_busy,
   input logic          hi_busy,
   input logic [PW-1:0] pcnt
);
   logic [5:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 6'h3f) since_rst <= since_rst + 1'b1;
   end

   p_boot_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 6'(BOOT_CYC)) |-> idle_n);

   p_blink_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hi_busy |-> idle_n);

   p_high_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((echo_err || next_req) && idle_n && !hi_busy) |=> !hi_busy);

   p_active_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_NORM && $past(mode == M_NORM) && $past(bus_active) && !lo_busy)
      |-> idle_n);

   p_lull_sat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= PW'(IDLE_CYC));
endmodule

bind bus_idle_sreq bus_idle_sreq_chk #(
   .BOOT_CYC (BOOT_CYC),
   .IDLE_CYC (IDLE_CYC),
   .PW       (PW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_active (bus_s),
   .echo_err   (echo_err),
   .next_req   (next_req),
   .idle_n     (idle_n),
   .mode       (mode),
   .lo_busy    (lo_busy),
   .hi_busy    (hi_busy),
   .pcnt       (pcnt)
);

// File: tb/bus_idle_sreq_bench.sv
module bus_idle_sreq_bench;
   localparam int unsigned CPU   = 8;
   localparam int unsigned IDLE  = (CPU * 2750 + 9) / 10;
   localparam int unsigned EARLY = (CPU * 2390 + 9) / 10;
   localparam int unsigned P1    = CPU;
   localparam int unsigned P2    = 2 * CPU;
   localparam int unsigned TAIL  = 40 + (CPU * 15 + 9) / 10;
   localparam int unsigned NV    = 4;
   // passive length before a rising edge, and whether a low pulse follows
   localparam int unsigned VLEN [NV] = '{EARLY - 1, EARLY, IDLE - 1, IDLE};
   localparam bit          VPULSE[NV] = '{1'b0, 1'b1, 1'b1, 1'b0};

   logic clk = 1'b0;
   logic rst_n, bus_active, xfer_done, echo_err, next_req;
   logic idle_n;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done_flag = 1'b0;

   always #10 clk = ~clk;

   bus_idle_sreq #(.CYC_PER_US(CPU)) u_bus_idle_sreq (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_active (bus_active),
      .xfer_done  (xfer_done),
      .echo_err   (echo_err),
      .next_req   (next_req),
      .idle_n     (idle_n)
   );

   task automatic tick(input int unsigned n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp);
      n_chk++;
      if (idle_n !== exp) begin
         n_fail++;
         $display("FAIL %s: idle_n=%b expected %b at %0t", req, idle_n, exp, $time);
      end
   endtask

   task automatic finish_up;
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic strobe_next;
      next_req = 1'b1; tick(1); next_req = 1'b0;
   endtask

   task automatic strobe_echo;
      echo_err = 1'b1; tick(1); echo_err = 1'b0;
   endtask

   task automatic strobe_done;
      xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
   endtask

   initial begin
      #(20 * 190000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: idle_n=%b expected run end", idle_n);
      finish_up();
   end

   initial begin
      rst_n = 1'b0; bus_active = 1'b0; xfer_done = 1'b0;
      echo_err = 1'b0; next_req = 1'b0;
      #5 check("R3 in reset", 1'b1);
      tick(3);
      rst_n = 1'b1;
      tick(16); check("R3 boot high", 1'b1);
      tick(1);  check("R3 boot end", 1'b0);
      tick(100); check("R4 waiting", 1'b0);

      strobe_echo();       check("R8 blink start", 1'b1);
      tick(P2 - 1);        check("R8 blink last", 1'b1);
      tick(1);             check("R8 blink over", 1'b0);

      strobe_done();       check("R4 tail first", 1'b0);
      tick(TAIL - 1);      check("R4 tail last", 1'b0);
      tick(1);             check("R4 released", 1'b1);
      tick(IDLE - 1);      check("R5 no early idle", 1'b1);
      tick(1);             check("R1 idle reached", 1'b0);

      strobe_done();       check("R11 done ignored", 1'b0);
      tick(TAIL + 5);      check("R11 still idle", 1'b0);

      strobe_next();       check("R9 blink start", 1'b1);
      tick(P2 - 1);        check("R9 blink last", 1'b1);
      tick(1);             check("R9 blink over", 1'b0);

      bus_active = 1'b1;
      tick(1);             check("R2 active clears", 1'b1);
      tick(3);
      bus_active = 1'b0;
      tick(IDLE - 1);      check("R1 one short", 1'b1);
      strobe_next();       check("R10 next while high", 1'b0);

      bus_active = 1'b1; tick(3);
      bus_active = 1'b0; tick(EARLY);
      bus_active = 1'b1;
      strobe_echo();       check("R10 echo while high", 1'b0);
      tick(P1 + 2);

      for (int i = 0; i < NV; i++) begin
         bus_active = 1'b1; tick(3);
         bus_active = 1'b0; tick(VLEN[i]);
         check("R1 R7 before rise", (VLEN[i] >= IDLE) ? 1'b0 : 1'b1);
         bus_active = 1'b1; tick(1);
         check("R6 R7 R2 after rise", VPULSE[i] ? 1'b0 : 1'b1);
         if (VPULSE[i]) begin
            tick(P1 - 1);  check("R6 pulse last", 1'b0);
            tick(1);       check("R6 pulse over", 1'b1);
         end else begin
            tick(2);       check("R2 R7 stays high", 1'b1);
         end
      end

      rst_n = 1'b0;
      #2 check("R3 re-reset", 1'b1);
      tick(2);
      rst_n = 1'b1;
      tick(16); check("R3 reboot high", 1'b1);
      tick(1);  check("R3 reboot end", 1'b0);

      finish_up();
   end
endmodule